// File: doc/BRIEF.md
# Serial Output-Enable Control Slave

This block listens on a two-wire serial bus as a write-only target. It turns the bytes a bus master sends into a 16-bit control image. Ten bits of that image switch individual differential clock output pairs on or off. A bit at 1 keeps its pair driving. A bit at 0 puts that pair into high impedance. After reset every pair is on, so a system that never programs the block still gets all of its clocks.

A transaction begins with a START condition. The master then sends a 7-bit target address and a direction bit. When the address matches and the direction is write, the block pulls the data line low for the acknowledge bit. The data bytes that follow fill the control registers strictly in order: the low byte first, then the high byte. No register-address byte is sent, and the registers cannot be reached out of order. Each new START begins again at the low byte. Extra bytes are acknowledged and thrown away. A STOP ends the transaction, and any byte already written stays in place.

The bus lines are oversampled by a fast system clock through a synchronizer. The system clock must run at least twenty times the bus bit rate, which suits standard-mode traffic at 100 kbit/s. The data line is open-drain: the block never drives it high, it only asks for it to be pulled low.

Top module: `pair_enable_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the control image reads all ones, all ten pair enables are 1 and the data line is not pulled low.
- R2: An address byte whose upper seven bits equal DEV_ADDR and whose least significant bit (the direction bit) is 0 is acknowledged by pulling the data line low for the ninth clock.
- R3: An address byte that does not match, or that has the direction bit set to 1, is not acknowledged. The data bytes that follow it in the same transaction are neither acknowledged nor stored.
- R4: Bits arrive most significant first. The first data byte after a matched address loads image bits [7:0] and the second loads bits [15:8]. Each byte takes effect once the falling clock edge after its eighth bit has been seen.
- R5: Data bytes after the second one in a transaction are acknowledged and leave the image unchanged.
- R6: Every START, including a repeated START without an earlier STOP, sends the next data byte to image bits [7:0].
- R7: A STOP ends the transaction. Bytes already stored keep their values, and a register that was not written in that transaction keeps its old value.
- R8: Pair enable i equals image bit i for i from 0 to 9. A 1 means the pair is enabled and a 0 means it is in high impedance.
- R9: The data line is pulled low only during acknowledge bits that R2 or R5 call for, or that data bytes of an addressed transaction call for. At all other times it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_low_o | output | 1 | When 1, the pad pulls the data line low (acknowledge) |
| reg_image_o | output | 16 | Both control registers, high byte in [15:8] |
| pair_en_o | output | 10 | Enable per output pair, 1 = driving, 0 = high impedance |

## Verification
The bench builds the block with DEV_ADDR = 7'h2C, REG_BYTES = 2, NUM_PAIRS = 10 and SYNC_STAGES = 2. It drives the bus at a quarter-bit of ten system clocks, which gives forty-fold oversampling. The two-register depth means a third and a fourth byte in one transaction reach the discard path. The chosen address lets the bench offer a target that differs only in its lowest address bit, and a read request to the correct address. Ten pairs out of sixteen bits let the bench show that the upper six bits of the high byte are stored but drive no enable.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_DATA     = 3'd3,
    ST_DATA_ACK = 3'd4
  } pe_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/pe_bus_sync.sv
module pe_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned PW = STAGES + 1;

  logic [PW-1:0] scl_q, scl_nxt;
  logic [PW-1:0] sda_q, sda_nxt;
  logic          scl_now, scl_old, sda_old;

  always_comb begin
    scl_nxt = {scl_q[PW-2:0], scl_i};
    sda_nxt = {sda_q[PW-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_nxt;
      sda_q <= sda_nxt;
    end
  end

  assign scl_now = scl_q[STAGES-1];
  assign scl_old = scl_q[STAGES];
  assign sda_s   = sda_q[STAGES-1];
  assign sda_old = sda_q[STAGES];

  assign scl_rise  =  scl_now & ~scl_old;
  assign scl_fall  = ~scl_now &  scl_old;
  assign start_det =  scl_now &  scl_old &  sda_old & ~sda_s;
  assign stop_det  =  scl_now &  scl_old & ~sda_old &  sda_s;

endmodule

// File: rtl/pe_byte_engine.sv
module pe_byte_engine
  import pe_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter int unsigned REG_BYTES = 2,
  localparam int unsigned PTRW     = $clog2(REG_BYTES + 1),
  localparam int unsigned IDXW     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              wr_en,
  output logic [IDXW-1:0]   wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ack_drive,
  output pe_state_t         state_o,
  output logic [PTRW-1:0]   ptr_o
);

  localparam logic [PTRW-1:0] PTR_END  = PTRW'(REG_BYTES);
  localparam logic [3:0]      BIT_LAST = 4'd8;

  pe_state_t         st_q, st_nxt;
  logic [3:0]        bit_q, bit_nxt;
  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic [PTRW-1:0]   ptr_q, ptr_nxt;
  logic              ack_q, ack_nxt;
  logic              byte_done;
  logic              addr_hit;

  assign byte_done = scl_fall && (bit_q == BIT_LAST);
  assign addr_hit  = (sh_q[7:1] == DEV_ADDR) && !sh_q[0];

  always_comb begin
    st_nxt  = st_q;
    bit_nxt = bit_q;
    sh_nxt  = sh_q;
    ptr_nxt = ptr_q;
    ack_nxt = ack_q;
    wr_en   = 1'b0;
    if (stop_det) begin
      st_nxt  = ST_IDLE;
      ack_nxt = 1'b0;
    end else if (start_det) begin
      st_nxt  = ST_ADDR;
      bit_nxt = '0;
      ptr_nxt = '0;
      ack_nxt = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && (bit_q != BIT_LAST)) begin
            sh_nxt  = {sh_q[BYTE_W-2:0], sda_s};
            bit_nxt = bit_q + 4'd1;
          end else if (byte_done) begin
            if (st_q == ST_ADDR) begin
              st_nxt  = addr_hit ? ST_ADDR_ACK : ST_IDLE;
              ack_nxt = addr_hit;
            end else begin
              st_nxt  = ST_DATA_ACK;
              ack_nxt = 1'b1;
              if (ptr_q < PTR_END) begin
                wr_en   = 1'b1;
                ptr_nxt = ptr_q + 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            st_nxt  = ST_DATA;
            bit_nxt = '0;
            ack_nxt = 1'b0;
          end
        end
        default: begin
          st_nxt = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      bit_q <= bit_nxt;
      sh_q  <= sh_nxt;
      ptr_q <= ptr_nxt;
      ack_q <= ack_nxt;
    end
  end

  assign wr_idx    = ptr_q[IDXW-1:0];
  assign wr_data   = sh_q;
  assign ack_drive = ack_q;
  assign state_o   = st_q;
  assign ptr_o     = ptr_q;

endmodule

// File: rtl/pe_reg_bank.sv
module pe_reg_bank
  import pe_pkg::*;
#(
  parameter int unsigned REG_BYTES = 2,
  localparam int unsigned IDXW     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1,
  localparam int unsigned IMG_W    = REG_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [IMG_W-1:0]  image_o
);

  for (genvar g = 0; g < REG_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q, byte_nxt;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDXW'(g));

    always_comb begin
      byte_nxt = byte_q;
      if (hit) byte_nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '1;
      else        byte_q <= byte_nxt;
    end

    assign image_o[g*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/pair_enable_ctrl.sv
module pair_enable_ctrl
  import pe_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned REG_BYTES   = 2,
  parameter int unsigned NUM_PAIRS   = 10,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IMG_W      = REG_BYTES * BYTE_W,
  localparam int unsigned PTRW       = $clog2(REG_BYTES + 1),
  localparam int unsigned IDXW       = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_drive_low_o,
  output logic [IMG_W-1:0]     reg_image_o,
  output logic [NUM_PAIRS-1:0] pair_en_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic              wr_en_w;
  logic [IDXW-1:0]   wr_idx_w;
  logic [BYTE_W-1:0] wr_data_w;
  pe_state_t         state_w;
  logic [PTRW-1:0]   ptr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  pe_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
  );

  pe_byte_engine #(.DEV_ADDR(DEV_ADDR), .REG_BYTES(REG_BYTES)) u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w),
    .wr_en     (wr_en_w),
    .wr_idx    (wr_idx_w),
    .wr_data   (wr_data_w),
    .ack_drive (sda_drive_low_o),
    .state_o   (state_w),
    .ptr_o     (ptr_w)
  );

  pe_reg_bank #(.REG_BYTES(REG_BYTES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en_w),
    .wr_idx  (wr_idx_w),
    .wr_data (wr_data_w),
    .image_o (reg_image_o)
  );

  assign pair_en_o = reg_image_o[NUM_PAIRS-1:0];

endmodule

// File: rtl/pe_checker.sv
module pe_checker
  import pe_pkg::*;
#(
  parameter int unsigned IMG_W = 16,
  parameter int unsigned PTRW  = 2,
  parameter int unsigned LIMIT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IMG_W-1:0] image,
  input logic             drive,
  input pe_state_t        state,
  input logic [PTRW-1:0]  ptr,
  input logic             scl_fall,
  input logic             start_det
);

  AST_RESET_ONES: assert property (@(posedge clk)
    !rst_n |=> (image == {IMG_W{1'b1}})); // R1

  AST_DRIVE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !drive); // R3

  AST_IMAGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(image) |-> $past(scl_fall)); // R4

  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTRW'(LIMIT)); // R5

  AST_START_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> (ptr == '0)); // R6

endmodule

bind pair_enable_ctrl pe_checker #(
  .IMG_W (IMG_W),
  .PTRW  (PTRW),
  .LIMIT (REG_BYTES)
) u_pe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .image     (reg_image_o),
  .drive     (sda_drive_low_o),
  .state     (state_w),
  .ptr       (ptr_w),
  .scl_fall  (scl_fall_w),
  .start_det (start_w)
);

// File: tb/pair_enable_ctrl_bench.sv
module pair_enable_ctrl_bench;

  localparam logic [6:0] ADDR = 7'h2C;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_line;
  logic drv;
  logic [15:0] img;
  logic [9:0] pen;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int chg_cyc = 0;
  bit done = 0;
  bit live = 0;

  logic [15:0] exp_img;
  bit exp_drv;
  bit m_active;
  int m_ptr;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = sda_m & ~drv;

  pair_enable_ctrl #(
    .DEV_ADDR(ADDR), .REG_BYTES(2), .NUM_PAIRS(10), .SYNC_STAGES(2)
  ) u_pair_enable_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low_o(drv), .reg_image_o(img), .pair_en_o(pen)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference model compared on every clock once outputs have settled
  always @(negedge clk) begin
    if (live && !done && (cyc - chg_cyc) > 6) begin
      chk(img == exp_img, "R4/R7 image", img, exp_img);
      chk(pen == exp_img[9:0], "R8 pair enables", {6'd0, pen}, {6'd0, exp_img[9:0]});
      chk(drv == exp_drv, "R9 data line drive", {15'd0, drv}, {15'd0, exp_drv});
    end
  end

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
    m_ptr = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
    m_active = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit is_addr, input string tag);
    bit exp_ack;
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0;
      if (i == 0) begin
        if (is_addr) begin
          m_active = (b[7:1] == ADDR) && !b[0];
          exp_ack = m_active;
        end else begin
          exp_ack = m_active;
          if (m_active && m_ptr < 2) begin
            exp_img[m_ptr*8 +: 8] = b;
            m_ptr++;
          end
        end
        exp_drv = exp_ack;
        chg_cyc = cyc;
      end
      wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    got = !sda_line;
    chk(got == exp_ack, tag, {15'd0, got}, {15'd0, exp_ack});
    wq(1);
    scl_m = 1'b0;
    exp_drv = 1'b0;
    chg_cyc = cyc;
    wq(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    exp_img = 16'hFFFF; exp_drv = 0; m_active = 0; m_ptr = 0;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(img == 16'hFFFF, "R1 image at reset", img, 16'hFFFF);
    chk(pen == 10'h3FF, "R1 enables at reset", {6'd0, pen}, 16'h03FF);
    chk(drv == 1'b0, "R1 line released at reset", {15'd0, drv}, 16'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(img == 16'hFFFF, "R1 image after release", img, 16'hFFFF);
    live = 1;

    // R2 / R4: two data bytes
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'hA5, 0, "R4 first byte ack");
    send_byte(8'h3C, 0, "R4 second byte ack");
    bus_stop();
    wq(1);
    chk(img == 16'h3CA5, "R4 image after two bytes", img, 16'h3CA5);
    chk(pen == 10'h0A5, "R8 enables follow image", {6'd0, pen}, 16'h00A5);

    // R3: mismatched address, then data ignored
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, 1, "R3 wrong address nack");
    send_byte(8'h00, 0, "R3 data after nack ignored");
    bus_stop();
    wq(1);
    chk(img == 16'h3CA5, "R3 image unchanged", img, 16'h3CA5);

    // R3: read request
    bus_start();
    send_byte({ADDR, 1'b1}, 1, "R3 read request nack");
    send_byte(8'h12, 0, "R3 data after read ignored");
    bus_stop();

    // R7: partial transaction
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'h0F, 0, "R7 single byte ack");
    bus_stop();
    wq(1);
    chk(img == 16'h3C0F, "R7 high byte kept", img, 16'h3C0F);

    // R5: overflow bytes acknowledged, discarded
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'h11, 0, "R4 byte ack");
    send_byte(8'h02, 0, "R4 byte ack");
    send_byte(8'h77, 0, "R5 third byte ack");
    send_byte(8'h88, 0, "R5 fourth byte ack");
    bus_stop();
    wq(1);
    chk(img == 16'h0211, "R5 extra bytes discarded", img, 16'h0211);

    // R6: repeated start resets pointer
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'hEE, 0, "R6 byte before restart");
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R6 address after restart");
    send_byte(8'h55, 0, "R6 byte after restart");
    bus_stop();
    wq(1);
    chk(img == 16'h0255, "R6 restart targets low byte", img, 16'h0255);

    // R8: all pairs off, upper bits stored but unused
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'h00, 0, "R8 byte ack");
    send_byte(8'hFC, 0, "R8 byte ack");
    bus_stop();
    wq(1);
    chk(pen == 10'h000, "R8 all pairs high impedance", {6'd0, pen}, 16'h0000);
    chk(img == 16'hFC00, "R8 upper bits stored", img, 16'hFC00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule